// File: doc/BRIEF.md
# UART Receiver Hunt Controller

This block sits behind the character assembler of a UART receiver and decides which received characters are passed on to the buffer logic. A hunt command deactivates reception and drops any message in progress. Reception resumes on one of two conditions, chosen by a mode input. In idle mode, one full idle character time must be seen on the line. In address mode, a character whose address bit is set must arrive, and that character is itself kept as the opening character of the new message.

Break sequences that arrive while the receiver is hunting are counted in a saturating event counter and raise a sticky interrupt flag. A write-one-to-clear input drops the flag, and a synchronous clear input zeroes the counter. Bit sampling, framing and buffer handling belong to the surrounding receiver.

Top module: `uart_hunt_ctrl`

## Requirements
- R1: After reset the block is hunting, the break counter reads 0, the break interrupt and the abort output are low, and a character with the address bit clear is not accepted.
- R2: While hunting, `char_acc_o` stays low for every character except an address-marked character in address mode (`resume_on_addr_i` = 1).
- R3: In idle mode (`resume_on_addr_i` = 0), an `idle_char_i` strobe while hunting ends the hunt from the next cycle on. A character in the same cycle as that strobe is not accepted, and the address bit has no effect.
- R4: In address mode, a character with `char_addr_i` = 1 that arrives while hunting is accepted in the same cycle with `char_first_o` = 1, and reception continues. In this mode `idle_char_i` does not end a hunt.
- R5: `char_first_o` is high exactly with the first character accepted after a hunt ends or after an `idle_char_i` strobe, and is low on every other accepted character.
- R6: `hunt_cmd_i` is honoured in any cycle. The block is hunting from the next cycle, a character in the command's cycle is not accepted, and the command wins over a same-cycle exit condition.
- R7: `abort_o` is a one-cycle pulse in the cycle after `hunt_cmd_i`, and only if the receiver was running with at least one character accepted since the last hunt or idle strobe.
- R8: A `break_i` strobe while hunting increments `brk_cnt_o` by one, visible in the next cycle. A break while running leaves the counter and the interrupt unchanged.
- R9: `brk_cnt_o` saturates at 0xFFFF and stays there on further breaks.
- R10: `brk_cnt_clr_i` zeroes the counter in the next cycle and wins over a same-cycle increment.
- R11: `brk_irq_o` is set by a break while hunting and held until `brk_irq_clr_i` is high. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resume_on_addr_i | input | 1 | Exit condition: 0 = idle line, 1 = address-marked character |
| hunt_cmd_i | input | 1 | Enter-hunt command strobe |
| char_vld_i | input | 1 | Received character strobe |
| char_addr_i | input | 1 | Address bit of the strobed character |
| idle_char_i | input | 1 | One full idle character time seen |
| break_i | input | 1 | Break sequence received |
| brk_irq_clr_i | input | 1 | Write-one-to-clear for the break interrupt |
| brk_cnt_clr_i | input | 1 | Synchronous clear of the break counter |
| char_acc_o | output | 1 | Character is passed on |
| char_first_o | output | 1 | Accepted character opens a message |
| abort_o | output | 1 | Message in progress was dropped |
| brk_irq_o | output | 1 | Sticky break interrupt |
| brk_cnt_o | output | 16 | Saturating break event count |

## Verification
The counter's saturation point is the hardest state to reach, because only breaks that arrive while hunting advance it. The bench holds the block in address mode with no address-marked characters and then strobes 65,540 breaks in a row, so the counter passes 0xFFFF while a clear arrives close by. The other corners come from random stimulus with high strobe rates in both modes: a hunt command on the same cycle as an exit, an idle strobe together with a character, and an interrupt clear together with a break. A cycle model in the bench follows all of these.

// File: rtl/uart_hunt_pkg.sv
package uart_hunt_pkg;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_e;

    typedef enum logic [0:0] {
        RESUME_IDLE = 1'b0,
        RESUME_ADDR = 1'b1
    } resume_mode_e;

    typedef struct packed {
        logic vld;
        logic addr;
        logic idle;
        logic brk;
    } rx_evt_t;

    localparam int unsigned BRK_CNT_W_DEF = 16;

    // Exit condition of a hunt for the given mode and line event.
    function automatic logic hunt_exit(input resume_mode_e mode, input rx_evt_t ev);
        if (mode == RESUME_ADDR) return ev.vld && ev.addr;
        return ev.idle;
    endfunction

    // Next value of a saturating counter with clear priority.
    function automatic logic [BRK_CNT_W_DEF-1:0] sat_next(
        input logic [BRK_CNT_W_DEF-1:0] cur,
        input logic inc,
        input logic clr
    );
        if (clr) return '0;
        if (inc && (cur != {BRK_CNT_W_DEF{1'b1}})) return cur + 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/uart_hunt_fsm.sv
module uart_hunt_fsm
    import uart_hunt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  resume_mode_e mode,
    input  logic         hunt_cmd,
    input  rx_evt_t      ev,
    output logic         hunting,
    output logic         acc,
    output logic         first,
    output logic         abort_p
);

    rx_state_e state_q, state_d;
    logic      in_msg_q, in_msg_d;
    logic      abort_q;
    logic      exit_now;

    always_comb begin
        exit_now = (state_q == ST_HUNT) && hunt_exit(mode, ev);
        acc = ev.vld && !hunt_cmd &&
              ((state_q == ST_RUN) || ((mode == RESUME_ADDR) && ev.addr));
        first = acc && !in_msg_q;

        state_d = state_q;
        if (hunt_cmd)      state_d = ST_HUNT;
        else if (exit_now) state_d = ST_RUN;

        in_msg_d = in_msg_q;
        if (hunt_cmd)     in_msg_d = 1'b0;
        else if (acc)     in_msg_d = 1'b1;
        else if (ev.idle) in_msg_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            in_msg_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            in_msg_q <= in_msg_d;
            abort_q  <= hunt_cmd && (state_q == ST_RUN) && in_msg_q;
        end
    end

    assign hunting = (state_q == ST_HUNT);
    assign abort_p = abort_q;

endmodule

// File: rtl/uart_hunt_brk.sv
module uart_hunt_brk
    import uart_hunt_pkg::*;
#(
    parameter int unsigned CNT_W = BRK_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hunting,
    input  logic             brk,
    input  logic             irq_clr,
    input  logic             cnt_clr,
    output logic             irq,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             event_hit;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    assign event_hit = hunting && brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (cnt_clr)
                cnt_q <= '0;
            else if (event_hit && (cnt_q != CNT_MAX))
                cnt_q <= cnt_q + 1'b1;

            if (event_hit)    irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

endmodule

// File: rtl/uart_hunt_ctrl.sv
module uart_hunt_ctrl
    import uart_hunt_pkg::*;
#(
    parameter int unsigned CNT_W = BRK_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resume_on_addr_i,
    input  logic             hunt_cmd_i,
    input  logic             char_vld_i,
    input  logic             char_addr_i,
    input  logic             idle_char_i,
    input  logic             break_i,
    input  logic             brk_irq_clr_i,
    input  logic             brk_cnt_clr_i,
    output logic             char_acc_o,
    output logic             char_first_o,
    output logic             abort_o,
    output logic             brk_irq_o,
    output logic [CNT_W-1:0] brk_cnt_o
);

    rx_evt_t      ev;
    resume_mode_e mode;
    logic         hunting;

    always_comb begin
        ev.vld  = char_vld_i;
        ev.addr = char_addr_i;
        ev.idle = idle_char_i;
        ev.brk  = break_i;
        mode    = resume_on_addr_i ? RESUME_ADDR : RESUME_IDLE;
    end

    uart_hunt_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .hunt_cmd (hunt_cmd_i),
        .ev       (ev),
        .hunting  (hunting),
        .acc      (char_acc_o),
        .first    (char_first_o),
        .abort_p  (abort_o)
    );

    uart_hunt_brk #(.CNT_W(CNT_W)) u_brk (
        .clk     (clk),
        .rst     (rst),
        .hunting (hunting),
        .brk     (ev.brk),
        .irq_clr (brk_irq_clr_i),
        .cnt_clr (brk_cnt_clr_i),
        .irq     (brk_irq_o),
        .cnt     (brk_cnt_o)
    );

endmodule

// File: rtl/uart_hunt_chk.sv
module uart_hunt_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             hunting,
    input logic             resume_on_addr_i,
    input logic             hunt_cmd_i,
    input logic             char_vld_i,
    input logic             char_addr_i,
    input logic             break_i,
    input logic             brk_irq_clr_i,
    input logic             brk_cnt_clr_i,
    input logic             char_acc_o,
    input logic             char_first_o,
    input logic             abort_o,
    input logic             brk_irq_o,
    input logic [CNT_W-1:0] brk_cnt_o
);

    // R2
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (hunting && !resume_on_addr_i) |-> !char_acc_o);

    // R4
    addr_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (hunting && resume_on_addr_i && char_vld_i && char_addr_i && !hunt_cmd_i)
        |-> (char_acc_o && char_first_o));

    // R6
    hunt_enter_chk: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd_i |=> hunting);

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    // R7
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!hunt_cmd_i) |=> !abort_o);

    // R8
    run_brk_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!hunting && !brk_cnt_clr_i) |=> (brk_cnt_o == $past(brk_cnt_o)));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        ((&brk_cnt_o) && !brk_cnt_clr_i) |=> (&brk_cnt_o));

    // R10
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        brk_cnt_clr_i |=> (brk_cnt_o == '0));

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_irq_o && !brk_irq_clr_i) |=> brk_irq_o);

    // R11
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hunting && break_i) |=> brk_irq_o);

endmodule

bind uart_hunt_ctrl uart_hunt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .hunting          (hunting),
    .resume_on_addr_i (resume_on_addr_i),
    .hunt_cmd_i       (hunt_cmd_i),
    .char_vld_i       (char_vld_i),
    .char_addr_i      (char_addr_i),
    .break_i          (break_i),
    .brk_irq_clr_i    (brk_irq_clr_i),
    .brk_cnt_clr_i    (brk_cnt_clr_i),
    .char_acc_o       (char_acc_o),
    .char_first_o     (char_first_o),
    .abort_o          (abort_o),
    .brk_irq_o        (brk_irq_o),
    .brk_cnt_o        (brk_cnt_o)
);

// File: tb/tb_uart_hunt_ctrl.sv
`timescale 1ns/1ps
module tb_uart_hunt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0, hunt_i = 1'b0, vld_i = 1'b0, addr_i = 1'b0;
    logic        idle_i = 1'b0, brk_i = 1'b0, iclr_i = 1'b0, cclr_i = 1'b0;
    logic        acc_o, first_o, abort_o, irq_o;
    logic [15:0] cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    bit m_hunt, m_inmsg, m_abort, m_irq;
    int m_cnt;

    always #4 clk = ~clk;

    uart_hunt_ctrl dut (
        .clk(clk), .rst(rst), .resume_on_addr_i(mode_i), .hunt_cmd_i(hunt_i),
        .char_vld_i(vld_i), .char_addr_i(addr_i), .idle_char_i(idle_i),
        .break_i(brk_i), .brk_irq_clr_i(iclr_i), .brk_cnt_clr_i(cclr_i),
        .char_acc_o(acc_o), .char_first_o(first_o), .abort_o(abort_o),
        .brk_irq_o(irq_o), .brk_cnt_o(cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic bit exp_acc();
        return vld_i && !hunt_i && (!m_hunt || (mode_i && addr_i));
    endfunction

    // One clock: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input bit md, input bit hc, input bit v, input bit a,
                        input bit idl, input bit b, input bit ic, input bit cc);
        bit ea, ef;
        @(negedge clk);
        chk("R7 abort", int'(abort_o), int'(m_abort));
        chk("R8 R11 break irq", int'(irq_o), int'(m_irq));
        chk("R8 R9 R10 break count", int'(cnt_o), m_cnt);
        mode_i = md; hunt_i = hc; vld_i = v; addr_i = a;
        idle_i = idl; brk_i = b; iclr_i = ic; cclr_i = cc;
        #1;
        ea = exp_acc();
        ef = ea && !m_inmsg;
        chk("R2 R3 R4 R6 accept", int'(acc_o), int'(ea));
        chk("R5 first", int'(first_o), int'(ef));
        @(posedge clk);
        m_abort = hc && !m_hunt && m_inmsg;
        if (cc) m_cnt = 0;
        else if (m_hunt && b && m_cnt < 65535) m_cnt++;
        if (m_hunt && b) m_irq = 1'b1;
        else if (ic) m_irq = 1'b0;
        if (hc) m_inmsg = 1'b0;
        else if (ea) m_inmsg = 1'b1;
        else if (idl) m_inmsg = 1'b0;
        if (hc) m_hunt = 1'b1;
        else if (m_hunt && (md ? (v && a) : idl)) m_hunt = 1'b0;
    endtask

    task automatic rnd_phase(input bit md, input int n, input int p_hunt, input int p_brk);
        for (int i = 0; i < n; i++) begin
            step(md, ($urandom % 100) < p_hunt, ($urandom % 100) < 50,
                 ($urandom % 100) < 25, ($urandom % 100) < 15,
                 ($urandom % 100) < p_brk, ($urandom % 100) < 10,
                 ($urandom % 100) < 3);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        m_hunt = 1'b1; m_inmsg = 1'b0; m_abort = 1'b0; m_irq = 1'b0; m_cnt = 0;
        // R1: reset state, a plain character is refused
        @(negedge clk);
        chk("R1 count", int'(cnt_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 abort", int'(abort_o), 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0);
        // R3: idle strobe with a character, then a character is accepted
        step(0, 0, 1, 1, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        // R7: hunt with a message in progress, then with none
        step(0, 1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0);
        // R4: idle does not release in address mode; address char does
        step(1, 0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0);
        // R8: break while running is ignored
        step(1, 0, 0, 0, 0, 1, 0, 0);
        // R6: hunt command beats an exit in the same cycle
        step(1, 1, 1, 1, 0, 0, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        // R11: set beats clear, then clear works
        step(1, 0, 0, 0, 0, 1, 1, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        // R10: clear beats increment
        step(1, 0, 0, 0, 0, 1, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        rnd_phase(0, 3000, 8, 20);
        rnd_phase(1, 3000, 8, 20);
        rnd_phase(0, 2000, 30, 40);
        rnd_phase(1, 2000, 30, 40);
        // R9: drive the counter into saturation while hunting
        step(1, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 65540; i++) step(1, 0, 0, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0, 1, 0, 1);
        step(1, 0, 0, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule